// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler with Latency Scoreboard

This block chooses, in every clock cycle, one warp from a pool of resident warps and issues either one or two instructions from it. Each warp presents its next two decoded instructions: slot 0 is the older one and slot 1 the younger. For each register there is a down-counter in a scoreboard kept per warp. When an instruction issues, the counter of its destination register is loaded with the fixed latency of the instruction's class. While the counter is not zero, the register is pending.

Nothing reports completion from outside. Pending bits expire purely by counting down. The issue decision is combinational from the present inputs and the present scoreboard state. The scoreboard counters and the round-robin pointer update at the rising clock edge that ends the cycle in which the issue was made. The surrounding pipeline uses `issue_valid`, `issue_warp` and `issue_count` to pop one or two entries from the chosen warp's instruction buffer.

Top module: `ws_warp_sched`

## Requirements
- R1: Each instruction is a field of 3*RID_W+3 bits, where RID_W = log2(NUM_REGS). From bit 0 upward the fields are: src0 (RID_W bits), src1 (RID_W bits), dst (RID_W bits), class (2 bits), and a valid bit at the top. Slot 0 of warp w occupies `ib_info[(2w)*IW +: IW]` and slot 1 occupies `ib_info[(2w+1)*IW +: IW]`. An instruction is ready only when it is valid and none of src0, src1 or dst is pending in its warp's scoreboard.
- R2: At most one warp issues per cycle. `issue_count` is 0 when `issue_valid` is low, and 1 or 2 when it is high.
- R3: A warp is a candidate only when its `warp_valid` bit is set and its slot-0 instruction is ready. No other warp is ever selected.
- R4: Slot 1 issues together with slot 0 (count 2) only when slot 1 is ready and none of its src0, src1 or dst equals slot 0's dst. Otherwise the count is 1.
- R5: Class 0 has a latency of LAT_ALU (4) cycles, class 1 has LAT_SFU (8), class 2 has LAT_LOAD (20), and class 3 uses the ALU latency. A destination written by an instruction issued at edge E blocks readiness in the L cycles that follow and is free from edge E+L.
- R6: Among the candidates, the first one at or after the warp following the last issuing warp is chosen, wrapping around. After reset, warp 0 has first priority.
- R7: Slot 1 never issues on its own. A warp whose slot 0 is blocked issues nothing, even if slot 1 is ready.
- R8: Reset clears every pending register in every warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_valid | input | NUM_WARPS | One bit per resident warp |
| ib_info | input | NUM_WARPS*2*IW | Two decoded instructions per warp, in the layout of R1 |
| issue_valid | output | 1 | A warp issues in this cycle |
| issue_warp | output | log2(NUM_WARPS) | Index of the issuing warp |
| issue_count | output | 2 | Number of instructions issued (0, 1 or 2) |

## Verification
The issue outputs are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives each stimulus at a falling edge and samples one nanosecond later, before the rising edge that commits it. The effects on the scoreboard and on the round-robin pointer show up only in the cycle after that rising edge. A destination issued with latency L is therefore expected to block for exactly L sampled cycles and to release on sample L+1. The stimulus table and the latency loops are laid out one row per cycle to match this timing.

// File: rtl/ws_pkg.sv
package ws_pkg;
   typedef enum logic [1:0] {
      CL_ALU  = 2'd0,
      CL_SFU  = 2'd1,
      CL_LOAD = 2'd2,
      CL_AUX  = 2'd3
   } ws_cls_e;

   function automatic int unsigned cls_latency(input logic [1:0] cls,
                                               input int unsigned l_alu,
                                               input int unsigned l_sfu,
                                               input int unsigned l_ld);
      case (ws_cls_e'(cls))
         CL_SFU:  return l_sfu;
         CL_LOAD: return l_ld;
         default: return l_alu;
      endcase
   endfunction
endpackage

// File: rtl/ws_ready.sv
module ws_ready #(
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
   input  logic                ins_vld,
   input  logic [RID_W-1:0]    src0,
   input  logic [RID_W-1:0]    src1,
   input  logic [RID_W-1:0]    dst,
   input  logic [NUM_REGS-1:0] pend,
   output logic                ready
);
   assign ready = ins_vld && !pend[src0] && !pend[src1] && !pend[dst];
endmodule

// File: rtl/ws_sb_bank.sv
module ws_sb_bank #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned CNT_W    = 5,
   localparam int unsigned RID_W = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_a_en,
   input  logic [RID_W-1:0]    set_a_reg,
   input  logic [CNT_W-1:0]    set_a_lat,
   input  logic                set_b_en,
   input  logic [RID_W-1:0]    set_b_reg,
   input  logic [CNT_W-1:0]    set_b_lat,
   output logic [NUM_REGS-1:0] pend
);
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [RID_W-1:0] RIDX = RID_W'(r);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              cnt <= '0;
         else if (set_a_en && set_a_reg == RIDX)  cnt <= set_a_lat;
         else if (set_b_en && set_b_reg == RIDX)  cnt <= set_b_lat;
         else if (cnt != '0)                      cnt <= cnt - 1'b1;
      end
      assign pend[r] = (cnt != '0);
   end
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
   parameter int unsigned NUM_WARPS = 64,
   localparam int unsigned WID_W = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] req,
   output logic                 grant_vld,
   output logic [WID_W-1:0]     grant_idx
);
   logic [WID_W-1:0] last_q;
   int unsigned cand;

   always_comb begin
      grant_vld = 1'b0;
      grant_idx = '0;
      cand      = 0;
      for (int i = 0; i < NUM_WARPS; i++) begin
         cand = (int'(last_q) + 1 + i) % NUM_WARPS;
         if (!grant_vld && req[cand]) begin
            grant_vld = 1'b1;
            grant_idx = WID_W'(cand);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_q <= WID_W'(NUM_WARPS - 1);
      else if (grant_vld) last_q <= grant_idx;
   end
endmodule

// File: rtl/ws_warp_sched.sv
module ws_warp_sched #(
   parameter int unsigned NUM_WARPS = 64,
   parameter int unsigned NUM_REGS  = 8,
   parameter int unsigned LAT_ALU   = 4,
   parameter int unsigned LAT_SFU   = 8,
   parameter int unsigned LAT_LOAD  = 20,
   localparam int unsigned WID_W = $clog2(NUM_WARPS),
   localparam int unsigned RID_W = $clog2(NUM_REGS),
   localparam int unsigned IW    = 3 * RID_W + 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_WARPS-1:0]         warp_valid,
   input  logic [NUM_WARPS*2*IW-1:0]    ib_info,
   output logic                         issue_valid,
   output logic [WID_W-1:0]             issue_warp,
   output logic [1:0]                   issue_count
);
   import ws_pkg::*;

   localparam int unsigned LAT_M1  = (LAT_ALU > LAT_SFU) ? LAT_ALU : LAT_SFU;
   localparam int unsigned LAT_MAX = (LAT_M1 > LAT_LOAD) ? LAT_M1 : LAT_LOAD;
   localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);

   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("ws_warp_sched: NUM_WARPS must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << RID_W) != NUM_REGS) begin : g_bad_regs
      $error("ws_warp_sched: NUM_REGS must be a power of two, at least 2");
   end
   if (LAT_ALU < 1 || LAT_SFU < 1 || LAT_LOAD < 1) begin : g_bad_lat
      $error("ws_warp_sched: every latency must be at least 1");
   end

   logic [NUM_WARPS-1:0] w_req;
   logic [NUM_WARPS-1:0] w_dual;
   logic                 grant_vld;
   logic [WID_W-1:0]     grant_idx;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [IW-1:0]       ia, ib;
      logic [RID_W-1:0]    a_s0, a_s1, a_d, b_s0, b_s1, b_d;
      logic [1:0]          a_cls, b_cls;
      logic                a_v, b_v, a_rdy, b_rdy, indep, sel;
      logic [NUM_REGS-1:0] pend;

      assign ia    = ib_info[(2*w)*IW +: IW];
      assign ib    = ib_info[(2*w+1)*IW +: IW];
      assign a_s0  = ia[RID_W-1:0];
      assign a_s1  = ia[2*RID_W-1:RID_W];
      assign a_d   = ia[3*RID_W-1:2*RID_W];
      assign a_cls = ia[3*RID_W+1:3*RID_W];
      assign a_v   = ia[IW-1];
      assign b_s0  = ib[RID_W-1:0];
      assign b_s1  = ib[2*RID_W-1:RID_W];
      assign b_d   = ib[3*RID_W-1:2*RID_W];
      assign b_cls = ib[3*RID_W+1:3*RID_W];
      assign b_v   = ib[IW-1];

      ws_ready #(.NUM_REGS(NUM_REGS)) u_rdy_a (
         .ins_vld(a_v), .src0(a_s0), .src1(a_s1), .dst(a_d), .pend(pend), .ready(a_rdy));
      ws_ready #(.NUM_REGS(NUM_REGS)) u_rdy_b (
         .ins_vld(b_v), .src0(b_s0), .src1(b_s1), .dst(b_d), .pend(pend), .ready(b_rdy));

      assign indep     = (b_s0 != a_d) && (b_s1 != a_d) && (b_d != a_d);
      assign w_req[w]  = warp_valid[w] && a_rdy;
      assign w_dual[w] = b_rdy && indep;
      assign sel       = grant_vld && (grant_idx == WID_W'(w));

      ws_sb_bank #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_sb (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_a_en  (sel),
         .set_a_reg (a_d),
         .set_a_lat (CNT_W'(cls_latency(a_cls, LAT_ALU, LAT_SFU, LAT_LOAD))),
         .set_b_en  (sel && w_dual[w]),
         .set_b_reg (b_d),
         .set_b_lat (CNT_W'(cls_latency(b_cls, LAT_ALU, LAT_SFU, LAT_LOAD))),
         .pend      (pend)
      );
   end

   ws_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (w_req),
      .grant_vld (grant_vld),
      .grant_idx (grant_idx)
   );

   assign issue_valid = grant_vld;
   assign issue_warp  = grant_idx;
   assign issue_count = !grant_vld ? 2'd0 : (w_dual[grant_idx] ? 2'd2 : 2'd1);
endmodule

// File: rtl/ws_warp_sched_chk.sv
module ws_warp_sched_chk #(
   parameter int unsigned NUM_WARPS = 64,
   parameter int unsigned NUM_REGS  = 8,
   localparam int unsigned WID_W = $clog2(NUM_WARPS),
   localparam int unsigned RID_W = $clog2(NUM_REGS),
   localparam int unsigned IW    = 3 * RID_W + 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_WARPS-1:0]      warp_valid,
   input logic [NUM_WARPS*2*IW-1:0] ib_info,
   input logic                      issue_valid,
   input logic [WID_W-1:0]          issue_warp,
   input logic [1:0]                issue_count
);
   logic [IW-1:0]    c_a, c_b;
   logic [RID_W-1:0] c_a_d, c_b_d, c_b_s0, c_b_s1;

   assign c_a    = ib_info[(2*int'(issue_warp))*IW +: IW];
   assign c_b    = ib_info[(2*int'(issue_warp)+1)*IW +: IW];
   assign c_a_d  = c_a[3*RID_W-1:2*RID_W];
   assign c_b_d  = c_b[3*RID_W-1:2*RID_W];
   assign c_b_s0 = c_b[RID_W-1:0];
   assign c_b_s1 = c_b[2*RID_W-1:RID_W];

   AST_COUNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> (issue_count == 2'd1 || issue_count == 2'd2));  // R2
   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !issue_valid |-> issue_count == 2'd0);  // R2
   AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> (warp_valid[issue_warp] && c_a[IW-1]));  // R3
   AST_NO_WARP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (warp_valid == '0) |-> !issue_valid);  // R3
   AST_DUAL_INDEP: assert property (@(posedge clk) disable iff (!rst_n) (issue_count == 2'd2) |-> (c_b[IW-1] && c_b_d != c_a_d && c_b_s0 != c_a_d && c_b_s1 != c_a_d));  // R4
   AST_PEND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |=> !(issue_valid && issue_warp == $past(issue_warp) && (c_a_d == $past(c_a_d) || ($past(issue_count) == 2'd2 && c_a_d == $past(c_b_d)))));  // R1
endmodule

bind ws_warp_sched ws_warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/ws_warp_sched_bench.sv
module ws_warp_sched_bench;
   localparam int NW = 4;
   localparam int IW = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NW-1:0]   warp_valid = '0;
   logic [NW*2*IW-1:0] ib_info = '0;
   logic            issue_valid;
   logic [1:0]      issue_warp;
   logic [1:0]      issue_count;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ws_warp_sched #(.NUM_WARPS(NW), .NUM_REGS(8)) u_ws_warp_sched (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .ib_info(ib_info),
      .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_count(issue_count));

   // R1 layout: {valid, class[1:0], dst, src1, src0}
   function automatic logic [IW-1:0] ins(input logic v, input logic [1:0] c,
                                         input int d, input int s1, input int s0);
      return {v, c, 3'(d), 3'(s1), 3'(s0)};
   endfunction

   typedef struct packed {
      logic [3:0]    wv;
      logic [IW-1:0] i0;
      logic [IW-1:0] i1;
      logic          ev;
      logic [1:0]    ew;
      logic [1:0]    en;
   } row_t;

   localparam logic [IW-1:0] IA = ins(1, 0, 1, 3, 2);
   localparam logic [IW-1:0] IB = ins(1, 0, 4, 6, 5);
   localparam logic [IW-1:0] IC = ins(1, 0, 5, 6, 1);
   localparam logic [IW-1:0] ID = ins(1, 0, 7, 3, 2);
   localparam logic [IW-1:0] IE = ins(1, 0, 7, 0, 0);
   localparam int NROWS = 20;
   localparam row_t TBL [NROWS] = '{
      '{4'b0000, IA, '0, 1'b0, 2'd0, 2'd0},
      '{4'b1111, IA, IB, 1'b1, 2'd0, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd1, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd2, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd3, 2'd2},
      '{4'b1111, IA, IB, 1'b0, 2'd0, 2'd0},
      '{4'b1111, IA, IB, 1'b1, 2'd0, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd1, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd2, 2'd2},
      '{4'b1111, IA, IB, 1'b1, 2'd3, 2'd2},
      '{4'b1111, IA, IC, 1'b0, 2'd0, 2'd0},
      '{4'b1111, IA, IC, 1'b1, 2'd0, 2'd1},
      '{4'b1111, ID, IE, 1'b1, 2'd1, 2'd1},
      '{4'b1111, ID, IE, 1'b1, 2'd2, 2'd1},
      '{4'b1111, ID, IE, 1'b1, 2'd3, 2'd1},
      '{4'b1111, ID, IE, 1'b1, 2'd0, 2'd1},
      '{4'b1111, ID, IE, 1'b0, 2'd0, 2'd0},
      '{4'b1111, ID, IE, 1'b1, 2'd1, 2'd1},
      '{4'b1011, ID, IE, 1'b0, 2'd0, 2'd0},
      '{4'b1011, ID, IE, 1'b1, 2'd3, 2'd1}
   };

   task automatic apply(input logic [3:0] wv, input logic [IW-1:0] i0, input logic [IW-1:0] i1);
      warp_valid = wv;
      for (int w = 0; w < NW; w++) begin
         ib_info[(2*w)*IW +: IW]   = i0;
         ib_info[(2*w+1)*IW +: IW] = i1;
      end
   endtask

   task automatic check(input logic ev, input logic [1:0] ew, input logic [1:0] en, input string tag);
      #1;
      checks++;
      if (issue_valid !== ev || issue_count !== (ev ? en : 2'd0) || (ev && issue_warp !== ew)) begin
         errs++;
         $display("FAIL %s: got v=%0b w=%0d n=%0d exp v=%0b w=%0d n=%0d",
                  tag, issue_valid, issue_warp, issue_count, ev, ew, ev ? en : 2'd0);
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      apply(4'b0000, '0, '0);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R5/R7: dependent slot 0 must wait exactly lat cycles; slot 1 stays ready meanwhile
   task automatic lat_test(input logic [1:0] cls, input int lat, input string tag);
      do_reset();
      apply(4'b0001, ins(1, cls, 2, 0, 0), '0);
      check(1, 0, 1, tag);
      apply(4'b0001, ins(1, 0, 3, 0, 2), ins(1, 0, 6, 5, 5));
      for (int j = 0; j < lat; j++) check(0, 0, 0, tag);
      check(1, 0, 2, tag);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL R2 watchdog: got hang exp completion");
         report();
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state: nothing issues with no valid warp (R8, R3)
      check(0, 0, 0, "R8 idle after reset");
      // table walk: R1 R2 R3 R4 R5 R6 in one cycle per row
      for (int k = 0; k < NROWS; k++) begin
         apply(TBL[k].wv, TBL[k].i0, TBL[k].i1);
         check(TBL[k].ev, TBL[k].ew, TBL[k].en, $sformatf("R1/R4/R6 table row %0d", k));
      end
      // R8: warp 1 holds r7 pending; after reset it issues at once
      do_reset();
      apply(4'b0010, IE, '0);
      check(1, 1, 1, "R8 pending cleared");
      // R6: pointer restarts at warp 0
      do_reset();
      apply(4'b1111, IA, '0);
      check(1, 0, 1, "R6 warp 0 first after reset");
      // R3: valid warp with empty slot 0 is never picked
      do_reset();
      apply(4'b0001, '0, IB);
      check(0, 0, 0, "R3 empty slot 0");
      // R5 per class, R7 slot 1 held back while slot 0 waits
      lat_test(2'd2, 20, "R5/R7 load latency");
      lat_test(2'd1, 8, "R5/R7 sfu latency");
      lat_test(2'd0, 4, "R5 alu latency");
      lat_test(2'd3, 4, "R5 class 3 latency");
      done = 1'b1;
      report();
   end
endmodule